// File: doc/BRIEF.md
# Hierarchical Interrupt Status Aggregator

This block gathers interrupt events from three source groups (processor, fault and credit counter) and folds them into a single top-level status byte. The top-level status drives one level-sensitive interrupt line toward the host. Each group has its own status byte and its own mask byte. Single-cycle pulses on a group's event inputs set status bits. Software clears a status bit by writing a one to it.

Each group is condensed into one summary bit of the top-level status. The processor and fault summaries are recomputed in the same clock edge in which their group's status or mask changes. The counter summary is normally refreshed only after a programmable hold-off. A new counter event, or a change to the counter mask, arms or re-arms a countdown. The summary is sampled when that countdown expires. A host that clears a summary bit in the top-level status sees it stay clear until its group next changes.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, the top-level, processor and fault status bytes read 0x00, the counter status byte reads 0xF0, all four mask bytes read 0x00 and `irq` is low.
- R2: A write to a status byte clears exactly the bits that are one in the written data. Bits written as zero keep their value.
- R3: A pulse on bit n of `cpu_evt`, `err_evt` or `cnt_evt` sets bit n of that group's status byte at the next clock edge.
- R4: Bit 7 of the top-level status is the fault summary. It is updated to the OR of (fault status AND fault mask) at the same edge that changes the fault status or mask. When neither of them changes, the bit holds, so a host clear of bit 7 persists.
- R5: Bit 6 of the top-level status is the processor summary. It follows the same update rule as R4, using the processor status and mask.
- R6: Bit 4 of the top-level status is the counter summary. A change of the counter mask, or an event that sets a counter status bit that was clear, loads a countdown of CNT_DELAY cycles. The summary takes the OR of (counter status AND counter mask) at the edge CNT_DELAY cycles after the last such trigger. A new trigger while counting restarts the full delay.
- R7: A write to the counter status byte that clears at least one set bit updates bit 4 at that same edge, without waiting for the countdown.
- R8: `irq` is high exactly when (top-level status AND top-level mask) is nonzero.
- R9: The registers sit at these addresses: top-level status 0x400, processor status 0x401, fault status 0x402, counter status 0x403, top-level mask 0x418, processor mask 0x419, fault mask 0x41A, counter mask 0x41B. A read has no side effect. Reads of any other address return 0x00, and writes to any other address change nothing.
- R10: Bits 5 and 3 to 0 of the top-level status always read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for `addr` / `wr_data` |
| addr | input | AW | Register address for read and write |
| wr_data | input | DW | Write data |
| rd_data | output | DW | Combinational read data for `addr` |
| cpu_evt | input | DW | Processor event pulses, one per status bit |
| err_evt | input | DW | Fault event pulses, one per status bit |
| cnt_evt | input | DW | Counter event pulses, one per status bit |
| irq | output | 1 | Level interrupt to the host |

## Verification
On every cycle, the assertions check the following. The fault and processor summaries match their group's masked status whenever that group changes, and hold otherwise unless the host clears them. The counter summary moves only on a countdown expiry, a counter clear or a host clear. Write-one-to-clear leaves no written bit set, the reserved top-level bits stay zero, and the reset values appear after reset. Only the bench's scenarios can show some behaviours. These are the exact cycle at which a deferred counter summary appears, the restart of the countdown by a later event, the persistence of a host-cleared summary, and the fact that unmapped writes and reads disturb nothing.

// File: rtl/aggr_pkg.sv
package aggr_pkg;

    localparam int NUM_GRP = 3;
    localparam int GRP_CPU = 0;
    localparam int GRP_ERR = 1;
    localparam int GRP_CNT = 2;

    // summary bit positions inside the top-level status byte
    localparam int SUM_ERR_BIT = 7;
    localparam int SUM_CPU_BIT = 6;
    localparam int SUM_CNT_BIT = 4;

    // register addresses (12-bit space)
    localparam logic [11:0] A_TOP_STAT = 12'h400;
    localparam logic [11:0] A_CPU_STAT = 12'h401;
    localparam logic [11:0] A_ERR_STAT = 12'h402;
    localparam logic [11:0] A_CNT_STAT = 12'h403;
    localparam logic [11:0] A_TOP_MASK = 12'h418;
    localparam logic [11:0] A_CPU_MASK = 12'h419;
    localparam logic [11:0] A_ERR_MASK = 12'h41A;
    localparam logic [11:0] A_CNT_MASK = 12'h41B;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_TOP_STAT,
        SEL_CPU_STAT,
        SEL_ERR_STAT,
        SEL_CNT_STAT,
        SEL_TOP_MASK,
        SEL_CPU_MASK,
        SEL_ERR_MASK,
        SEL_CNT_MASK
    } reg_sel_e;

    typedef struct packed {
        logic               top_clr;
        logic               top_mask;
        logic [NUM_GRP-1:0] grp_clr;
        logic [NUM_GRP-1:0] grp_mask;
    } wr_strobe_t;

    function automatic reg_sel_e decode_addr(input logic [11:0] a);
        case (a)
            A_TOP_STAT: return SEL_TOP_STAT;
            A_CPU_STAT: return SEL_CPU_STAT;
            A_ERR_STAT: return SEL_ERR_STAT;
            A_CNT_STAT: return SEL_CNT_STAT;
            A_TOP_MASK: return SEL_TOP_MASK;
            A_CPU_MASK: return SEL_CPU_MASK;
            A_ERR_MASK: return SEL_ERR_MASK;
            A_CNT_MASK: return SEL_CNT_MASK;
            default:    return SEL_NONE;
        endcase
    endfunction

    function automatic logic [7:0] summary_mask();
        logic [7:0] m;
        m = '0;
        m[SUM_ERR_BIT] = 1'b1;
        m[SUM_CPU_BIT] = 1'b1;
        m[SUM_CNT_BIT] = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/aggr_decode.sv
module aggr_decode
    import aggr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    output reg_sel_e      sel,
    output wr_strobe_t    wr
);
    logic [11:0] a12;

    generate
        if (AW >= 12) begin : g_wide
            assign a12 = addr[11:0];
            logic upper_zero;
            if (AW > 12) begin : g_upper
                assign upper_zero = (addr[AW-1:12] == '0);
            end else begin : g_exact
                assign upper_zero = 1'b1;
            end
            assign sel = upper_zero ? decode_addr(a12) : SEL_NONE;
        end else begin : g_narrow
            assign a12 = {{(12-AW){1'b0}}, addr};
            assign sel = decode_addr(a12);
        end
    endgenerate

    always_comb begin
        wr = '0;
        if (wr_en) begin
            case (sel)
                SEL_TOP_STAT: wr.top_clr           = 1'b1;
                SEL_CPU_STAT: wr.grp_clr[GRP_CPU]  = 1'b1;
                SEL_ERR_STAT: wr.grp_clr[GRP_ERR]  = 1'b1;
                SEL_CNT_STAT: wr.grp_clr[GRP_CNT]  = 1'b1;
                SEL_TOP_MASK: wr.top_mask          = 1'b1;
                SEL_CPU_MASK: wr.grp_mask[GRP_CPU] = 1'b1;
                SEL_ERR_MASK: wr.grp_mask[GRP_ERR] = 1'b1;
                SEL_CNT_MASK: wr.grp_mask[GRP_CNT] = 1'b1;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/aggr_group.sv
module aggr_group #(
    parameter int            DW      = 8,
    parameter logic [DW-1:0] RST_VAL = '0
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] evt,
    input  logic          clr_we,
    input  logic          mask_we,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] mask_q,
    output logic          sum_nxt,
    output logic          touched,
    output logic          mask_changed,
    output logic          fresh_bit,
    output logic          clr_hit
);
    logic [DW-1:0] stat_d;
    logic [DW-1:0] mask_d;

    always_comb begin
        stat_d = stat_q;
        if (clr_we) begin
            stat_d = stat_q & ~wdata;
        end
        stat_d = stat_d | evt;
        mask_d = mask_we ? wdata : mask_q;
    end

    assign sum_nxt      = |(stat_d & mask_d);
    assign mask_changed = (mask_d != mask_q);
    assign touched      = (stat_d != stat_q) || mask_changed;
    assign fresh_bit    = |(evt & ~stat_q);
    assign clr_hit      = clr_we && |(stat_q & wdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= RST_VAL;
            mask_q <= '0;
        end else begin
            stat_q <= stat_d;
            mask_q <= mask_d;
        end
    end
endmodule

// File: rtl/aggr_defer_timer.sv
module aggr_defer_timer #(
    parameter int DELAY = 64
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    output logic expire,
    output logic busy
);
    localparam int CW = (DELAY < 2) ? 1 : $clog2(DELAY + 1);

    logic [CW-1:0] left_q;

    assign busy   = (left_q != '0);
    assign expire = (left_q == CW'(1)) && !arm;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q <= '0;
        end else if (arm) begin
            left_q <= CW'(DELAY);
        end else if (busy) begin
            left_q <= left_q - CW'(1);
        end
    end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import aggr_pkg::*;
#(
    parameter int DW        = 8,
    parameter int AW        = 12,
    parameter int CNT_DELAY = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wr_data,
    output logic [DW-1:0] rd_data,
    input  logic [DW-1:0] cpu_evt,
    input  logic [DW-1:0] err_evt,
    input  logic [DW-1:0] cnt_evt,
    output logic          irq
);
    localparam logic [DW-1:0] CNT_RST  = {{(DW/2){1'b1}}, {(DW-DW/2){1'b0}}};
    localparam int            DLY_USED = (CNT_DELAY < 1) ? 1 : CNT_DELAY;

    reg_sel_e   rd_sel;
    wr_strobe_t wr;

    logic [DW-1:0]      g_evt   [NUM_GRP];
    logic [DW-1:0]      g_stat  [NUM_GRP];
    logic [DW-1:0]      g_mask  [NUM_GRP];
    logic [NUM_GRP-1:0] g_sum, g_touch, g_mchg, g_fresh, g_clrhit;

    logic [DW-1:0] top_q, top_d, top_mask_q;
    logic [DW-1:0] cpu_stat_q, err_stat_q, cnt_stat_q;
    logic [DW-1:0] cpu_mask_q, err_mask_q, cnt_mask_q;
    logic          cnt_arm, cnt_expire, cnt_busy, cnt_refresh;

    aggr_decode #(.AW(AW)) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .sel   (rd_sel),
        .wr    (wr)
    );

    assign g_evt[GRP_CPU] = cpu_evt;
    assign g_evt[GRP_ERR] = err_evt;
    assign g_evt[GRP_CNT] = cnt_evt;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            localparam logic [DW-1:0] RV = (g == GRP_CNT) ? CNT_RST : '0;
            aggr_group #(.DW(DW), .RST_VAL(RV)) u_grp (
                .clk          (clk),
                .rst          (rst),
                .evt          (g_evt[g]),
                .clr_we       (wr.grp_clr[g]),
                .mask_we      (wr.grp_mask[g]),
                .wdata        (wr_data),
                .stat_q       (g_stat[g]),
                .mask_q       (g_mask[g]),
                .sum_nxt      (g_sum[g]),
                .touched      (g_touch[g]),
                .mask_changed (g_mchg[g]),
                .fresh_bit    (g_fresh[g]),
                .clr_hit      (g_clrhit[g])
            );
        end
    endgenerate

    assign cpu_stat_q = g_stat[GRP_CPU];
    assign err_stat_q = g_stat[GRP_ERR];
    assign cnt_stat_q = g_stat[GRP_CNT];
    assign cpu_mask_q = g_mask[GRP_CPU];
    assign err_mask_q = g_mask[GRP_ERR];
    assign cnt_mask_q = g_mask[GRP_CNT];

    // counter summary: deferred by a restartable countdown
    assign cnt_arm = g_mchg[GRP_CNT] || g_fresh[GRP_CNT];

    aggr_defer_timer #(.DELAY(DLY_USED)) u_tmr (
        .clk    (clk),
        .rst    (rst),
        .arm    (cnt_arm),
        .expire (cnt_expire),
        .busy   (cnt_busy)
    );

    assign cnt_refresh = cnt_expire || g_clrhit[GRP_CNT];

    always_comb begin
        top_d = top_q;
        if (wr.top_clr) begin
            top_d = top_q & ~wr_data;
        end
        if (g_touch[GRP_ERR]) begin
            top_d[SUM_ERR_BIT] = g_sum[GRP_ERR];
        end
        if (g_touch[GRP_CPU]) begin
            top_d[SUM_CPU_BIT] = g_sum[GRP_CPU];
        end
        if (cnt_refresh) begin
            top_d[SUM_CNT_BIT] = g_sum[GRP_CNT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            top_q      <= '0;
            top_mask_q <= '0;
        end else begin
            top_q <= top_d;
            if (wr.top_mask) begin
                top_mask_q <= wr_data;
            end
        end
    end

    assign irq = |(top_q & top_mask_q);

    always_comb begin
        case (rd_sel)
            SEL_TOP_STAT: rd_data = top_q;
            SEL_CPU_STAT: rd_data = cpu_stat_q;
            SEL_ERR_STAT: rd_data = err_stat_q;
            SEL_CNT_STAT: rd_data = cnt_stat_q;
            SEL_TOP_MASK: rd_data = top_mask_q;
            SEL_CPU_MASK: rd_data = cpu_mask_q;
            SEL_ERR_MASK: rd_data = err_mask_q;
            SEL_CNT_MASK: rd_data = cnt_mask_q;
            default:      rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst,
    input logic [DW-1:0] top_q,
    input logic          top_clr,
    input logic [DW-1:0] wr_data,
    input logic [DW-1:0] cpu_stat,
    input logic [DW-1:0] cpu_mask,
    input logic [DW-1:0] cpu_evt,
    input logic          cpu_clr,
    input logic [DW-1:0] err_stat,
    input logic [DW-1:0] err_mask,
    input logic [DW-1:0] cnt_stat,
    input logic [DW-1:0] cnt_mask,
    input logic [DW-1:0] top_mask,
    input logic          cnt_expire,
    input logic          cnt_clrhit
);
    localparam logic [DW-1:0] RSV = ~DW'(aggr_pkg::summary_mask());

    logic rst_prev = 1'b0;

    always_ff @(posedge clk) begin
        rst_prev <= rst;
        if (rst_prev && !rst) begin
            a_r1_reset_values : assert (top_q == '0 && cpu_stat == '0 && err_stat == '0 &&
                                        cnt_stat == {{(DW/2){1'b1}}, {(DW-DW/2){1'b0}}} &&
                                        cpu_mask == '0 && err_mask == '0 &&
                                        cnt_mask == '0 && top_mask == '0)
                else $error("R1 reset values wrong");
        end
    end

    a_r4_err_follow : assert property (@(posedge clk) disable iff (rst)
        (!$stable(err_stat) || !$stable(err_mask)) |->
            (top_q[aggr_pkg::SUM_ERR_BIT] == |(err_stat & err_mask)))
        else $error("R4 fault summary mismatch");

    a_r4_err_hold : assert property (@(posedge clk) disable iff (rst)
        ($stable(err_stat) && $stable(err_mask) && !$past(top_clr)) |->
            $stable(top_q[aggr_pkg::SUM_ERR_BIT]))
        else $error("R4 fault summary moved without cause");

    a_r5_cpu_follow : assert property (@(posedge clk) disable iff (rst)
        (!$stable(cpu_stat) || !$stable(cpu_mask)) |->
            (top_q[aggr_pkg::SUM_CPU_BIT] == |(cpu_stat & cpu_mask)))
        else $error("R5 processor summary mismatch");

    a_r6_cnt_cause : assert property (@(posedge clk) disable iff (rst)
        !$stable(top_q[aggr_pkg::SUM_CNT_BIT]) |->
            ($past(cnt_expire) || $past(cnt_clrhit) || $past(top_clr)))
        else $error("R6 counter summary moved without cause");

    a_r2_w1c_cpu : assert property (@(posedge clk) disable iff (rst)
        (cpu_clr && cpu_evt == '0) |=> ((cpu_stat & $past(wr_data)) == '0))
        else $error("R2 write-one-to-clear left a bit set");

    a_r10_reserved : assert property (@(posedge clk) disable iff (rst)
        (top_q & RSV) == '0)
        else $error("R10 reserved top-level bit set");
endmodule

bind irq_aggregator irq_aggregator_chk #(.DW(DW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .top_q      (top_q),
    .top_clr    (wr.top_clr),
    .wr_data    (wr_data),
    .cpu_stat   (cpu_stat_q),
    .cpu_mask   (cpu_mask_q),
    .cpu_evt    (cpu_evt),
    .cpu_clr    (wr.grp_clr[aggr_pkg::GRP_CPU]),
    .err_stat   (err_stat_q),
    .err_mask   (err_mask_q),
    .cnt_stat   (cnt_stat_q),
    .cnt_mask   (cnt_mask_q),
    .top_mask   (top_mask_q),
    .cnt_expire (cnt_expire),
    .cnt_clrhit (g_clrhit[aggr_pkg::GRP_CNT])
);

// File: tb/irq_aggregator_tb_top.sv
`timescale 1ns/1ps
module irq_aggregator_tb_top;
    localparam int DLY = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [11:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic [7:0]  cpu_evt = '0;
    logic [7:0]  err_evt = '0;
    logic [7:0]  cnt_evt = '0;
    logic [7:0]  rd_data;
    logic        irq;

    always #2.5 clk = ~clk;

    irq_aggregator #(.DW(8), .AW(12), .CNT_DELAY(DLY)) dut_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .addr    (addr),
        .wr_data (wdata),
        .rd_data (rd_data),
        .cpu_evt (cpu_evt),
        .err_evt (err_evt),
        .cnt_evt (cnt_evt),
        .irq     (irq)
    );

    typedef struct {
        bit          is_irq;
        logic [11:0] a;
        logic [7:0]  exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;

    // driver side
    task automatic wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic pulse(input logic [7:0] c, input logic [7:0] e, input logic [7:0] n);
        @(negedge clk);
        cpu_evt = c; err_evt = e; cnt_evt = n;
        @(negedge clk);
        cpu_evt = '0; err_evt = '0; cnt_evt = '0;
    endtask

    task automatic rd_chk(input logic [11:0] a, input logic [7:0] e, input string tag);
        @(negedge clk);
        addr = a;
        sb_q.push_back('{1'b0, a, e, tag});
    endtask

    task automatic irq_chk(input logic e, input string tag);
        @(negedge clk);
        sb_q.push_back('{1'b1, 12'h0, {7'b0, e}, tag});
    endtask

    // monitor side
    always begin
        @(negedge clk);
        #1;
        while (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq} : rd_data;
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.a, act, it.exp);
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog all-requirements actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_chk(12'h400, 8'h00, "R1 top status");
        rd_chk(12'h401, 8'h00, "R1 cpu status");
        rd_chk(12'h402, 8'h00, "R1 err status");
        rd_chk(12'h403, 8'hF0, "R1 cnt status");
        rd_chk(12'h418, 8'h00, "R1 top mask");
        rd_chk(12'h419, 8'h00, "R1 cpu mask");
        rd_chk(12'h41A, 8'h00, "R1 err mask");
        rd_chk(12'h41B, 8'h00, "R1 cnt mask");
        irq_chk(1'b0, "R1 irq");
        rd_chk(12'h404, 8'h00, "R9 unmapped read");

        // processor group
        pulse(8'h05, 8'h00, 8'h00);
        rd_chk(12'h401, 8'h05, "R3 cpu event sets");
        rd_chk(12'h400, 8'h00, "R5 masked off");
        wr(12'h419, 8'h04);
        rd_chk(12'h400, 8'h40, "R5 summary on mask change");
        irq_chk(1'b0, "R8 top mask zero");
        wr(12'h418, 8'h40);
        irq_chk(1'b1, "R8 irq asserted");
        wr(12'h401, 8'h04);
        rd_chk(12'h401, 8'h01, "R2 w1c cpu");
        rd_chk(12'h400, 8'h00, "R5 summary drops");
        irq_chk(1'b0, "R8 irq drops");

        // fault group
        pulse(8'h00, 8'h80, 8'h00);
        rd_chk(12'h402, 8'h80, "R3 err event sets");
        wr(12'h41A, 8'h80);
        rd_chk(12'h400, 8'h80, "R4 fault summary");
        wr(12'h400, 8'h80);
        rd_chk(12'h400, 8'h00, "R2 w1c top");
        rd_chk(12'h400, 8'h00, "R4 host clear persists");
        pulse(8'h00, 8'h01, 8'h00);
        rd_chk(12'h402, 8'h81, "R3 err second event");
        rd_chk(12'h400, 8'h80, "R4 re-evaluated on change");
        wr(12'h402, 8'hFF);
        rd_chk(12'h402, 8'h00, "R2 w1c err all");
        rd_chk(12'h400, 8'h00, "R4 summary drops");

        // counter group, deferred with restart
        wr(12'h41B, 8'h10);
        repeat (3) @(negedge clk);
        pulse(8'h00, 8'h00, 8'h01);
        repeat (2) @(negedge clk);
        rd_chk(12'h400, 8'h00, "R6 restart held off first expiry");
        repeat (3) @(negedge clk);
        rd_chk(12'h400, 8'h00, "R6 one cycle before expiry");
        rd_chk(12'h400, 8'h10, "R6 summary at expiry");
        rd_chk(12'h403, 8'hF1, "R3 cnt event sets");

        // counter clear is immediate
        wr(12'h403, 8'hF1);
        rd_chk(12'h400, 8'h00, "R7 immediate counter refresh");
        rd_chk(12'h403, 8'h00, "R2 w1c cnt");
        repeat (DLY + 2) @(negedge clk);
        rd_chk(12'h400, 8'h00, "R7 no later change");

        // unmapped write and side-effect-free reads
        wr(12'h404, 8'hFF);
        rd_chk(12'h401, 8'h01, "R9 unmapped write cpu status");
        rd_chk(12'h419, 8'h04, "R9 unmapped write cpu mask");
        rd_chk(12'h418, 8'h40, "R9 unmapped write top mask");
        rd_chk(12'h401, 8'h01, "R9 read has no side effect");

        // reserved bits and zero bits of a clear write
        wr(12'h418, 8'hFF);
        pulse(8'h04, 8'h00, 8'h00);
        rd_chk(12'h400, 8'h40, "R10 reserved bits zero");
        irq_chk(1'b1, "R8 irq with full mask");
        wr(12'h400, 8'h2F);
        rd_chk(12'h400, 8'h40, "R2 zero bits unchanged");

        @(negedge clk);
        #2;
        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule